// File: doc/BRIEF.md
# Single-Precision Compare Unit with Condition Flags

This block compares two IEEE 754 single-precision operands and reports the outcome as four condition flags: less-than, equal, greater-or-equal and unordered. It also raises an invalid-operation event. A request carries a first operand and either a second operand or an immediate constant. The immediate arrives already encoded as a single-precision value. The request also carries two mode bits. One mode bit negates the second operand's sign before the comparison. The other mode bit selects a signalling compare, which reports invalid whenever the inputs are unordered. When the signalling bit is clear, the compare is quiet and reports invalid only for trapping NaNs.

The unit always accepts requests. Each accepted request produces registered flags one clock later, marked by a single-cycle result-valid pulse. The flags keep their values until the next accepted request.

Top module: `fcmp_flags`

## Requirements
- R1: `in_ready` is always 1. Every cycle with `in_valid` high is an accepted request. `out_valid` is high in the cycle after an accepted request and low in the cycle after any cycle with `in_valid` low.
- R2: If either compared operand is a NaN (exponent all ones, fraction nonzero), the result is unordered: `flag_uo`=1 and `flag_lt`=`flag_eq`=`flag_ge`=0.
- R3: For ordered operands, `flag_uo`=0. Exactly one of `flag_lt` and `flag_ge` is 1, and `flag_eq`=1 only together with `flag_ge`=1.
- R4: +0 and -0 compare equal in every sign combination.
- R5: Non-NaN operands are ordered by sign and magnitude. Any negative value is below any positive value. Among two negatives, the one with the larger magnitude is the smaller value. Infinities (exponent all ones, fraction zero) are the extremes.
- R6: Denormals (exponent zero, fraction nonzero) are ordered by magnitude against each other, against zero and against normal numbers.
- R7: With `negate`=1, the first operand is compared against the second operand with its sign bit (bit 31) inverted.
- R8: With `use_imm`=1, `imm_val` replaces `op_b` as the second operand, and `op_b` has no effect.
- R9: With `signal_mode`=1, `invalid` equals `flag_uo` for the request.
- R10: With `signal_mode`=0, `invalid` is 1 only when a compared operand is a trapping NaN (exponent all ones, fraction bit 22 = 0, fraction nonzero). A non-trapping NaN (fraction bit 22 = 1) gives `invalid`=0.
- R11: After reset, `out_valid` and all flags are 0. Outputs stay unchanged in cycles with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken (always 1) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| imm_val | input | 32 | Immediate second operand, single-precision encoded |
| use_imm | input | 1 | Select `imm_val` instead of `op_b` |
| negate | input | 1 | Invert the sign of the second operand |
| signal_mode | input | 1 | Signalling compare: invalid on unordered |
| out_valid | output | 1 | Result present (one-cycle pulse) |
| flag_lt | output | 1 | First operand is less |
| flag_eq | output | 1 | Operands are equal |
| flag_ge | output | 1 | First operand is greater or equal |
| flag_uo | output | 1 | Operands are unordered |
| invalid | output | 1 | Invalid-operation event |

## Verification
Every result is due exactly one clock after the edge that accepts its request. The bench drives inputs on the falling edge and samples shortly after the next rising edge. At that point the flags and `out_valid` must match a reference computed in the same cycle. Idle cycles are also compared on that schedule. In an idle cycle, `out_valid` must be low and the flags must be unchanged. The reference orders non-NaN values by mapping each one to a signed integer key. It therefore shares no structure with the design's sign and magnitude decision logic.

// File: rtl/fcmp_flags.sv
module fcmp_flags #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic [EXP_W+FRAC_W:0]       imm_val,
  input  logic                        use_imm,
  input  logic                        negate,
  input  logic                        signal_mode,
  output logic                        out_valid,
  output logic                        flag_lt,
  output logic                        flag_eq,
  output logic                        flag_ge,
  output logic                        flag_uo,
  output logic                        invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic logic is_nan(input logic [W-1:0] x);
    return (&x[W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
  endfunction

  function automatic logic is_snan(input logic [W-1:0] x);
    return is_nan(x) && !x[FRAC_W-1];
  endfunction

  logic [W-1:0] b_sel, b_eff;
  logic [W-2:0] mag_a, mag_b;
  logic         sa, sb, unord, trap, zeros, m_lt, m_eq;
  logic         lt_c, eq_c, gt_c;

  assign in_ready = 1'b1;
  assign b_sel = use_imm ? imm_val : op_b;
  assign b_eff = {b_sel[W-1] ^ negate, b_sel[W-2:0]};
  assign sa    = op_a[W-1];
  assign sb    = b_eff[W-1];
  assign mag_a = op_a[W-2:0];
  assign mag_b = b_eff[W-2:0];
  assign m_lt  = mag_a < mag_b;
  assign m_eq  = mag_a == mag_b;
  assign zeros = ~|mag_a && ~|mag_b;
  assign unord = is_nan(op_a) || is_nan(b_eff);
  assign trap  = is_snan(op_a) || is_snan(b_eff);

  always_comb begin
    lt_c = 1'b0;
    eq_c = 1'b0;
    gt_c = 1'b0;
    if (unord) begin
      lt_c = 1'b0;
    end else if (zeros) begin
      eq_c = 1'b1;
    end else if (sa != sb) begin
      lt_c = sa;
      gt_c = sb;
    end else if (!sa) begin
      lt_c = m_lt;
      eq_c = m_eq;
      gt_c = !m_lt && !m_eq;
    end else begin
      lt_c = !m_lt && !m_eq;
      eq_c = m_eq;
      gt_c = m_lt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag_lt   <= 1'b0;
      flag_eq   <= 1'b0;
      flag_ge   <= 1'b0;
      flag_uo   <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flag_lt <= lt_c;
        flag_eq <= eq_c;
        flag_ge <= gt_c | eq_c;
        flag_uo <= unord;
        invalid <= signal_mode ? unord : trap;
      end
    end
  end
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        use_imm,
  input logic        signal_mode,
  input logic        out_valid,
  input logic        flag_lt,
  input logic        flag_eq,
  input logic        flag_ge,
  input logic        flag_uo,
  input logic        invalid
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_unordered_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_uo) |-> (!flag_lt && !flag_eq && !flag_ge));
  a_r3_ordered_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !flag_uo) |-> ((flag_lt != flag_ge) && !(flag_eq && !flag_ge)));
  a_r4_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_imm && op_a[30:0] == 31'd0 && op_b[30:0] == 31'd0) |=> flag_eq);
  a_r9_signal_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signal_mode) |=> (invalid == flag_uo));
  a_r10_quiet_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !signal_mode) |=> (!invalid || flag_uo));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(flag_lt) && $stable(flag_eq) && $stable(flag_ge)
                   && $stable(flag_uo) && $stable(invalid)));
endmodule

bind fcmp_flags fcmp_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .use_imm(use_imm), .signal_mode(signal_mode),
  .out_valid(out_valid), .flag_lt(flag_lt), .flag_eq(flag_eq),
  .flag_ge(flag_ge), .flag_uo(flag_uo), .invalid(invalid)
);

// File: tb/fcmp_flags_test.sv
`timescale 1ns/100ps
module fcmp_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, use_imm = 1'b0, negate = 1'b0, signal_mode = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, imm_val = '0;
  logic        in_ready, out_valid, flag_lt, flag_eq, flag_ge, flag_uo, invalid;
  int          n_tests = 0, n_fail = 0;
  logic [5:0]  held = 6'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fcmp_flags uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .imm_val(imm_val), .use_imm(use_imm),
    .negate(negate), .signal_mode(signal_mode), .out_valid(out_valid),
    .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_ge(flag_ge),
    .flag_uo(flag_uo), .invalid(invalid)
  );

  function automatic bit nan_of(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 23'd0;
  endfunction

  function automatic longint key_of(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  // {out_valid, lt, eq, ge, uo, inv}
  function automatic logic [5:0] model(input logic [31:0] a, input logic [31:0] b,
                                       input bit ui, input logic [31:0] im,
                                       input bit ng, input bit sg);
    logic [31:0] y;
    bit uo, tr, lt, eq, ge;
    y = ui ? im : b;
    y[31] = y[31] ^ ng;
    uo = nan_of(a) || nan_of(y);
    tr = (nan_of(a) && !a[22]) || (nan_of(y) && !y[22]);
    lt = !uo && key_of(a) < key_of(y);
    eq = !uo && key_of(a) == key_of(y);
    ge = !uo && key_of(a) >= key_of(y);
    return {1'b1, lt, eq, ge, uo, sg ? uo : tr};
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {out_valid, flag_lt, flag_eq, flag_ge, flag_uo, invalid};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input bit ui = 0, input logic [31:0] im = 0,
                     input bit ng = 0, input bit sg = 0);
    logic [5:0] exp;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; use_imm = ui; imm_val = im;
    negate = ng; signal_mode = sg;
    exp = model(a, b, ui, im, ng, sg);
    @(posedge clk); #1;
    check(tag, exp);
    held = exp;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    op_a = 32'h7FC0_0000; op_b = 32'h0; imm_val = 32'h0;
    @(posedge clk); #1;
    check(tag, {1'b0, held[4:0]});
  endtask

  localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000, P2 = 32'h4000_0000,
                          N2 = 32'hC000_0000, PZ = 32'h0, NZ = 32'h8000_0000,
                          PINF = 32'h7F80_0000, NINF = 32'hFF80_0000,
                          QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001,
                          D1 = 32'h0000_0001, D2 = 32'h0000_0100, MINN = 32'h0080_0000;

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset", 6'b0);
    n_tests++;
    if (in_ready !== 1'b1) begin n_fail++; $display("FAIL R1 ready: got %b expected 1", in_ready); end
    @(negedge clk); rst_n = 1'b1;
    idle("R11 idle after reset");
    req("R5 1<2", P1, P2);
    req("R5 2>1", P2, P1);
    req("R5 1==1", P1, P1);
    req("R5 -2<-1", N2, N1);
    req("R5 -1>-2", N1, N2);
    req("R5 -1<1", N1, P1);
    req("R5 -inf<-2", NINF, N2);
    req("R5 +inf>2", PINF, P2);
    req("R4 +0=-0", PZ, NZ);
    req("R4 -0=+0", NZ, PZ);
    req("R4 -0=-0", NZ, NZ);
    req("R6 d1<d2", D1, D2);
    req("R6 d2<minnorm", D2, MINN);
    req("R6 -d1<+0", D1 | 32'h8000_0000, PZ);
    req("R6 d1>-0", D1, NZ);
    req("R2 qnan a", QNAN, P1);
    req("R2 qnan b", P1, QNAN);
    req("R10 quiet qnan no inv", QNAN, QNAN);
    req("R10 quiet snan inv", SNAN, P1);
    req("R10 quiet snan b inv", P1, SNAN | 32'h8000_0000);
    req("R9 signal qnan inv", QNAN, P1, 0, 0, 0, 1);
    req("R9 signal ordered no inv", P1, P2, 0, 0, 0, 1);
    req("R7 negate 1 vs -(-1)", P1, N1, 0, 0, 1);
    req("R7 negate 1 vs -(1)", P1, P1, 0, 0, 1);
    req("R7 negate 0 vs -(0)", NZ, PZ, 0, 0, 1);
    req("R7 negate nan stays", P1, QNAN, 0, 0, 1, 1);
    req("R8 imm 2 ignores op_b", P1, N2, 1, P2);
    req("R8 imm nan ignores op_b", P1, P1, 1, QNAN);
    req("R8 imm negated", P1, QNAN, 1, N2, 1);
    idle("R1 out_valid low when idle");
    idle("R11 flags hold");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, im;
      a = $urandom; b = $urandom; im = $urandom;
      if (i % 5 == 0) a[30:23] = 8'hFF;
      if (i % 7 == 0) b[30:23] = 8'h00;
      if (i % 3 == 0) b = a ^ {($urandom_range(0, 1) == 1), 31'd0};
      if (i % 11 == 0) a[30:0] = 31'd0;
      req("R3 random", a, b, $urandom_range(0, 1) == 1, im,
          $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      if (i % 9 == 0) idle("R1 random idle");
    end
    idle("R1 final idle");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule